// File: doc/BRIEF.md
# Bitfield Extract/Insert Unit

This block is the bitfield datapath of a small macro execution engine. Each operation carries two 32-bit register operands, a 2-bit mode and three 5-bit immediate fields that come from the upper bits of the instruction word: a source bit position, a field length and a destination bit position. The unit either copies a field of operand B into operand A, or pulls a field out of B and moves it to a new position. In the two extract modes, the low bits of operand A provide one of the two shift amounts and an immediate field provides the other.

Operations enter on a valid/ready stream and results leave on a valid/ready stream. One result register sits between them. An operation is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the result register is empty, or when its result is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds and new input is refused. The producer may present an operation at any time and must hold it until it is accepted.

Top module: `bitfield_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_result` is 0.
- R2: Mode 0 (insert) takes the field `(B >> src) & M`, where `M = (1 << len) - 1`. It clears the bits `M << dst` in A and ORs the field, shifted left by `dst`, into A. In the instruction word, src sits in bits 17-21, len in bits 22-26 and dst in bits 27-31; they arrive on separate ports.
- R3: Mode 1 gives `((B >> A[4:0]) & M) << dst`.
- R4: Mode 2 gives `((B >> src) & M) << A[4:0]`.
- R5: When len is 0 the mask is empty. Mode 0 then returns A unchanged, and modes 1 and 2 return 0.
- R6: When A supplies a shift amount, only A[4:0] is used, and A[31:5] has no effect on the result.
- R7: Mode 3 returns 0 whatever the operands.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted operation appears on `out_result` with `out_valid` high one cycle later. When the result is taken and no operation is accepted in that cycle, `out_valid` falls.
- R9: While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` stay unchanged.
- R10: Field bits moved past bit 31 are lost, and bits vacated by shifts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted |
| in_mode | input | 2 | 0 insert, 1 extract with register right shift, 2 extract with register left shift, 3 zero |
| in_src_lsb | input | 5 | Source bit position |
| in_fld_len | input | 5 | Field length |
| in_dst_lsb | input | 5 | Destination bit position |
| in_opa | input | 32 | Operand A |
| in_opb | input | 32 | Operand B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result |

## Verification
Two functions of the output register can happen in one cycle: a held result drains and a new operation is captured. The bench creates this case by holding `out_ready` low with a second operation waiting, and then raising `out_ready`. At that edge the first result must leave and the second must be captured. The check is that `out_valid` stays high with no empty cycle and that `out_result` changes straight from the first expected value to the second.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [1:0] {
    BF_INSERT     = 2'd0,
    BF_XTR_RSHREG = 2'd1,
    BF_XTR_LSHREG = 2'd2,
    BF_RSVD       = 2'd3
  } bf_mode_e;
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  len,
  output logic [DATA_W-1:0] mask
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  // Lengths 0..DATA_W-1: length 0 yields an empty mask.
  assign mask = (ONE << len) - ONE;
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [POS_W-1:0]  rsh,
  input  logic [POS_W-1:0]  lsh,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] field
);
  logic [DATA_W-1:0] aligned;
  always_comb begin
    aligned = (value >> rsh) & mask;
    field   = aligned << lsh;
  end
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int POS_W          = $clog2(DATA_W),
  parameter bit SHARED_EXTRACT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [POS_W-1:0]  src,
  input  logic [POS_W-1:0]  len,
  input  logic [POS_W-1:0]  dst,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  bf_mode_e          op;
  logic [POS_W-1:0]  a_amt;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] fld_ins, fld_m1, fld_m2;
  logic [DATA_W-1:0] hole;

  assign op    = bf_mode_e'(mode);
  assign a_amt = a[POS_W-1:0];

  bfu_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
    .len  (len),
    .mask (mask)
  );

  generate
    if (SHARED_EXTRACT) begin : g_shared
      logic [POS_W-1:0]  rsh, lsh;
      logic [DATA_W-1:0] fld;
      always_comb begin
        rsh = (op == BF_XTR_RSHREG) ? a_amt : src;
        lsh = (op == BF_XTR_LSHREG) ? a_amt : dst;
      end
      bfu_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) u_x (
        .value (b), .rsh (rsh), .lsh (lsh), .mask (mask), .field (fld)
      );
      assign fld_ins = fld;
      assign fld_m1  = fld;
      assign fld_m2  = fld;
    end else begin : g_parallel
      bfu_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) u_ins (
        .value (b), .rsh (src), .lsh (dst), .mask (mask), .field (fld_ins)
      );
      bfu_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) u_m1 (
        .value (b), .rsh (a_amt), .lsh (dst), .mask (mask), .field (fld_m1)
      );
      bfu_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) u_m2 (
        .value (b), .rsh (src), .lsh (a_amt), .mask (mask), .field (fld_m2)
      );
    end
  endgenerate

  assign hole = mask << dst;

  always_comb begin
    unique case (op)
      BF_INSERT:     res = (a & ~hole) | fld_ins;
      BF_XTR_RSHREG: res = fld_m1;
      BF_XTR_LSHREG: res = fld_m2;
      default:       res = '0;
    endcase
  end

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (res == '0));
  // R5
  empty_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && len == '0) |-> (res == a));
  // R5
  empty_xtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1 || mode == 2'd2) && len == '0) |-> (res == '0));
  // R3 R4
  field_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd2) |-> ($countones(res) <= int'(len)));
endmodule

// File: rtl/bfu_out_reg.sv
module bfu_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DATA_W         = 32,
  parameter bit SHARED_EXTRACT = 1'b1,
  localparam int POS_W         = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [POS_W-1:0]  in_src_lsb,
  input  logic [POS_W-1:0]  in_fld_len,
  input  logic [POS_W-1:0]  in_dst_lsb,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result
);
  logic [DATA_W-1:0] comb_res;

  bfu_datapath #(
    .DATA_W(DATA_W), .POS_W(POS_W), .SHARED_EXTRACT(SHARED_EXTRACT)
  ) u_dp (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (in_mode),
    .src  (in_src_lsb),
    .len  (in_fld_len),
    .dst  (in_dst_lsb),
    .a    (in_opa),
    .b    (in_opb),
    .res  (comb_res)
  );

  bfu_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (comb_res),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_result)
  );
endmodule

// File: tb/test_bitfield_unit.sv
`timescale 1ns/1ps
module test_bitfield_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [4:0]  in_src_lsb = '0, in_fld_len = '0, in_dst_lsb = '0;
  logic [31:0] in_opa = '0, in_opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_src_lsb(in_src_lsb), .in_fld_len(in_fld_len),
    .in_dst_lsb(in_dst_lsb), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  // Fields: tag(4) mode(2) src(5) len(5) dst(5) a(32) b(32) expected(32)
  localparam int NV = 13;
  localparam logic [116:0] VEC [NV] = '{
    {4'd2,  2'd0, 5'd4,  5'd8,  5'd16, 32'hFFFFFFFF, 32'h00000AB0, 32'hFFABFFFF}, // R2
    {4'd2,  2'd0, 5'd0,  5'd4,  5'd0,  32'h12345678, 32'h0000000C, 32'h1234567C}, // R2
    {4'd10, 2'd0, 5'd0,  5'd8,  5'd28, 32'h0FFFFFF3, 32'h000000A5, 32'h5FFFFFF3}, // R10
    {4'd3,  2'd1, 5'd31, 5'd8,  5'd4,  32'h00000008, 32'h12345678, 32'h00000560}, // R3
    {4'd6,  2'd1, 5'd31, 5'd8,  5'd4,  32'hFFFFFFE8, 32'h12345678, 32'h00000560}, // R6
    {4'd4,  2'd2, 5'd16, 5'd4,  5'd0,  32'h0000000C, 32'h000B0000, 32'h0000B000}, // R4
    {4'd6,  2'd2, 5'd0,  5'd8,  5'd9,  32'h0000003C, 32'h000000FF, 32'hF0000000}, // R6 R10
    {4'd5,  2'd0, 5'd3,  5'd0,  5'd5,  32'hDEADBEEF, 32'hFFFFFFFF, 32'hDEADBEEF}, // R5
    {4'd5,  2'd1, 5'd3,  5'd0,  5'd5,  32'h00000000, 32'hFFFFFFFF, 32'h00000000}, // R5
    {4'd5,  2'd2, 5'd3,  5'd0,  5'd5,  32'h00000000, 32'hFFFFFFFF, 32'h00000000}, // R5
    {4'd7,  2'd3, 5'd0,  5'd8,  5'd0,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}, // R7
    {4'd3,  2'd1, 5'd0,  5'd31, 5'd1,  32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFE}, // R3
    {4'd4,  2'd2, 5'd31, 5'd1,  5'd0,  32'h00000020, 32'h80000000, 32'h00000001}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [116:0] v);
    in_mode    = v[112:111];
    in_src_lsb = v[110:106];
    in_fld_len = v[105:101];
    in_dst_lsb = v[100:96];
    in_opa     = v[95:64];
    in_opb     = v[63:32];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, out_valid}, 32'd0);
    chk("R1", out_result, 32'd0);
    // R8 ready when empty
    chk("R8", {31'd0, in_ready}, 32'd1);

    // Table walk
    out_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 vec%0d valid", i), {31'd0, out_valid}, 32'd1);
      chk($sformatf("R%0d vec%0d", VEC[i][116:113], i), out_result, VEC[i][31:0]);
    end
    // R8 drain with nothing accepted
    @(negedge clk);
    chk("R8 drain", {31'd0, out_valid}, 32'd0);

    // R9 back-pressure, then simultaneous drain and accept (R8)
    out_ready = 1'b0;
    drive(VEC[0]);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R9 first held", out_result, 32'hFFABFFFF);
    chk("R9 ready low", {31'd0, in_ready}, 32'd0);
    drive(VEC[3]);
    repeat (3) @(negedge clk);
    chk("R9 stable", out_result, 32'hFFABFFFF);
    chk("R9 valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #1;
    chk("R8 ready with out_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 back-to-back valid", {31'd0, out_valid}, 32'd1);
    chk("R8 back-to-back data", out_result, 32'h00000560);
    @(negedge clk);
    chk("R8 empty after drain", {31'd0, out_valid}, 32'd0);

    // R1 reset mid-run clears a pending result
    out_ready = 1'b0;
    drive(VEC[1]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset data", out_result, 32'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule